// File: doc/BRIEF.md
# Segment Descriptor Translation Unit

This block turns a 16-bit logical offset into a 24-bit physical address through a segment descriptor. It keeps four segment registers (extra, code, stack, data). Each register holds a selector, and the selector picks an entry in a small descriptor table held inside the block. Each descriptor gives a base, a limit and a descriptor privilege level (DPL). The kind of access picks the segment register. For data and stack accesses an override input can pick another register.

The block compares every access with the segment limit and with the privilege rule. It returns either the base plus the offset or a fault code, one cycle after the request. The current privilege level is the DPL of the descriptor that the code register points at, so rewriting that descriptor or that register changes the current level. Software-side machinery fills the table and the registers through plain write ports. Fetching descriptors from memory, gates and task switching belong to other blocks.

Top module: `seg_xlate_unit`

## Requirements
- R1: Each cycle with `acc_valid` high gives `rsp_valid` high on the next cycle. Every other cycle `rsp_valid` is low.
- R2: Access kind is encoded 0 fetch, 1 data read, 2 data write, 3 stack. With no override, fetch uses the code register, stack uses the stack register, and read and write use the data register.
- R3: Segment register codes are 0 extra, 1 code, 2 stack, 3 data. With `ovr_en` high, read, write and stack accesses use the register named by `ovr_seg`. For a fetch the override is ignored and the code register is always used.
- R4: Only the low 3 bits of a selector index the 8-entry descriptor table. The upper selector bits have no effect.
- R5: Descriptor word layout: limit in bits [15:0], base in bits [39:16], DPL in bits [41:40]. Bits [63:42] are ignored.
- R6: An access with no fault returns address = base + zero-extended offset, modulo 2^24, with fault code 0.
- R7: An offset above the limit gives fault code 1 (limit). An offset equal to the limit is allowed.
- R8: `cur_pl` equals the DPL of the descriptor selected by the code register. If `cur_pl` is numerically greater than the target DPL, the access gives fault code 2 (privilege). A limit fault takes priority over a privilege fault.
- R9: A faulted response drives `rsp_addr` to zero.
- R10: Table and register writes affect accesses from the next cycle on. An access in the same cycle as a write sees the old contents.
- R11: After a synchronous active-low reset, `rsp_valid`, `rsp_addr` and `rsp_fault` are zero, and all descriptors and selectors are zero, so `cur_pl` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| desc_we | input | 1 | Descriptor table write enable |
| desc_idx | input | 3 | Descriptor entry written |
| desc_wdata | input | 64 | Descriptor word |
| seg_we | input | 1 | Segment register write enable |
| seg_wid | input | 2 | Segment register written (R3 coding) |
| seg_wdata | input | 16 | Selector value |
| acc_valid | input | 1 | Access request |
| acc_kind | input | 2 | Access kind (R2 coding) |
| ovr_en | input | 1 | Segment override enable |
| ovr_seg | input | 2 | Override segment register |
| acc_ofs | input | 16 | Logical offset |
| rsp_valid | output | 1 | Response valid |
| rsp_addr | output | 24 | Physical address, zero on fault |
| rsp_fault | output | 2 | 0 none, 1 limit, 2 privilege |
| cur_pl | output | 2 | Current privilege level |

## Verification
Directed cases place the offset exactly at the limit and one above it, and set the current level equal to and above the target DPL. These separate a correct `>` comparison from an off-by-one and show that the limit fault wins when both checks fail. A fetch with the override set, a selector with junk upper bits, a descriptor with junk reserved bits, and a base near the top of the space show that the selection rules hold, that the ignored bits stay ignored, and that the sum wraps. A write issued in the same cycle as an access tells old contents from new. A long seeded random run mixes writes, kinds and overrides against a bench model.

// File: rtl/sdt_pkg.sv
// Shared constants, codes and the decoded descriptor type for the
// segment descriptor translation unit. Assumes a 64-bit descriptor word.
package sdt_pkg;
    localparam int OFS_W  = 16;
    localparam int BASE_W = 24;
    localparam int LIM_W  = 16;
    localparam int PL_W   = 2;
    localparam int SEL_W  = 16;
    localparam int DESC_W = 64;
    localparam int TBL_N  = 8;
    localparam int IDX_W  = $clog2(TBL_N);
    localparam int SEG_N  = 4;
    localparam int SEG_W  = $clog2(SEG_N);
    localparam int LIM_LO  = 0;
    localparam int BASE_LO = LIM_LO + LIM_W;
    localparam int PL_LO   = BASE_LO + BASE_W;

    typedef enum logic [1:0] {SEG_EXTRA = 2'd0, SEG_CODE = 2'd1,
                              SEG_STACK = 2'd2, SEG_DATA = 2'd3} seg_id_e;
    typedef enum logic [1:0] {ACC_FETCH = 2'd0, ACC_READ = 2'd1,
                              ACC_WRITE = 2'd2, ACC_STACK = 2'd3} acc_kind_e;
    typedef enum logic [1:0] {FLT_NONE = 2'd0, FLT_LIMIT = 2'd1,
                              FLT_PRIV = 2'd2, FLT_RSVD = 2'd3} fault_e;

    typedef struct packed {
        logic [BASE_W-1:0] base;
        logic [LIM_W-1:0]  limit;
        logic [PL_W-1:0]   dpl;
    } desc_t;
endpackage

// File: rtl/sdt_desc_table.sv
// Descriptor table: TBL_N entries kept in decoded form (reserved bits
// dropped), one write port and two combinational read ports.
// Assumes writes are visible to reads from the next cycle on.
module sdt_desc_table
    import sdt_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [IDX_W-1:0]   widx,
    input  logic [DESC_W-1:0]  wdata,
    input  logic [IDX_W-1:0]   ridx_acc,
    input  logic [IDX_W-1:0]   ridx_code,
    output desc_t              rd_acc,
    output desc_t              rd_code
);
    desc_t entry_q [TBL_N];
    desc_t wr_dec;
    logic  unused_rsvd;

    // Split the incoming word into its fields
    always_comb begin
        wr_dec.limit = wdata[LIM_LO +: LIM_W];
        wr_dec.base  = wdata[BASE_LO +: BASE_W];
        wr_dec.dpl   = wdata[PL_LO +: PL_W];
    end
    assign unused_rsvd = ^wdata[DESC_W-1:PL_LO+PL_W];

    // One storage register per entry
    for (genvar g = 0; g < TBL_N; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n)
                entry_q[g] <= '0;
            else if (we && widx == IDX_W'(g))
                entry_q[g] <= wr_dec;
        end
    end

    // Read ports
    assign rd_acc  = entry_q[ridx_acc];
    assign rd_code = entry_q[ridx_code];

    p_write_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> entry_q[$past(widx)].limit == $past(wdata[LIM_LO +: LIM_W])
            && entry_q[$past(widx)].base == $past(wdata[BASE_LO +: BASE_W])
            && entry_q[$past(widx)].dpl == $past(wdata[PL_LO +: PL_W]));
endmodule

// File: rtl/sdt_seg_regs.sv
// Segment register file and segment selection. Holds only the table
// index bits of each selector; picks the register from access kind and
// override, and always uses the code register for fetches.
module sdt_seg_regs
    import sdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [SEG_W-1:0]  wid,
    input  logic [SEL_W-1:0]  wdata,
    input  logic [1:0]        acc_kind,
    input  logic              ovr_en,
    input  logic [SEG_W-1:0]  ovr_seg,
    output logic [SEG_W-1:0]  acc_seg,
    output logic [IDX_W-1:0]  acc_idx,
    output logic [IDX_W-1:0]  code_idx
);
    logic [IDX_W-1:0] sel_q [SEG_N];
    logic unused_sel_hi;

    assign unused_sel_hi = ^wdata[SEL_W-1:IDX_W];

    // Selector registers, table index bits only
    for (genvar g = 0; g < SEG_N; g++) begin : g_seg
        always_ff @(posedge clk) begin
            if (!rst_n)
                sel_q[g] <= '0;
            else if (we && wid == SEG_W'(g))
                sel_q[g] <= wdata[IDX_W-1:0];
        end
    end

    // Pick the segment register for this access
    always_comb begin
        if (acc_kind == ACC_FETCH)
            acc_seg = SEG_CODE;
        else if (ovr_en)
            acc_seg = ovr_seg;
        else if (acc_kind == ACC_STACK)
            acc_seg = SEG_STACK;
        else
            acc_seg = SEG_DATA;
    end

    assign acc_idx  = sel_q[acc_seg];
    assign code_idx = sel_q[SEG_CODE];

    p_fetch_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
        acc_kind == ACC_FETCH |-> acc_idx == code_idx);
    p_override_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_en && acc_kind != ACC_FETCH) |-> acc_idx == sel_q[ovr_seg]);
endmodule

// File: rtl/sdt_check.sv
// Limit and privilege check with address sum. Purely combinational.
// Assumes the limit check has priority over the privilege check.
module sdt_check
    import sdt_pkg::*;
(
    input  desc_t              desc,
    input  logic [PL_W-1:0]    cpl,
    input  logic [OFS_W-1:0]   ofs,
    output logic [1:0]         fault,
    output logic [BASE_W-1:0]  addr
);
    // Decide the fault and form the address
    always_comb begin
        fault = FLT_NONE;
        addr  = '0;
        if (LIM_W'(ofs) > desc.limit)
            fault = FLT_LIMIT;
        else if (cpl > desc.dpl)
            fault = FLT_PRIV;
        else
            addr = desc.base + BASE_W'(ofs);
    end
endmodule

// File: rtl/seg_xlate_unit.sv
// Segment descriptor translation unit top. Selects a segment register,
// reads its descriptor, checks limit and privilege, and registers the
// result one cycle after the request.
module seg_xlate_unit
    import sdt_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                desc_we,
    input  logic [IDX_W-1:0]    desc_idx,
    input  logic [DESC_W-1:0]   desc_wdata,
    input  logic                seg_we,
    input  logic [SEG_W-1:0]    seg_wid,
    input  logic [SEL_W-1:0]    seg_wdata,
    input  logic                acc_valid,
    input  logic [1:0]          acc_kind,
    input  logic                ovr_en,
    input  logic [SEG_W-1:0]    ovr_seg,
    input  logic [OFS_W-1:0]    acc_ofs,
    output logic                rsp_valid,
    output logic [BASE_W-1:0]   rsp_addr,
    output logic [1:0]          rsp_fault,
    output logic [PL_W-1:0]     cur_pl
);
    logic [SEG_W-1:0]  acc_seg;
    logic [IDX_W-1:0]  acc_idx;
    logic [IDX_W-1:0]  code_idx;
    desc_t             acc_desc;
    desc_t             code_desc;
    logic [1:0]        chk_fault;
    logic [BASE_W-1:0] chk_addr;
    logic              unused_seg;

    assign unused_seg = ^acc_seg;

    sdt_seg_regs i_seg (
        .clk(clk), .rst_n(rst_n), .we(seg_we), .wid(seg_wid),
        .wdata(seg_wdata), .acc_kind(acc_kind), .ovr_en(ovr_en),
        .ovr_seg(ovr_seg), .acc_seg(acc_seg), .acc_idx(acc_idx),
        .code_idx(code_idx)
    );

    sdt_desc_table i_tbl (
        .clk(clk), .rst_n(rst_n), .we(desc_we), .widx(desc_idx),
        .wdata(desc_wdata), .ridx_acc(acc_idx), .ridx_code(code_idx),
        .rd_acc(acc_desc), .rd_code(code_desc)
    );

    assign cur_pl = code_desc.dpl;

    sdt_check i_chk (
        .desc(acc_desc), .cpl(cur_pl), .ofs(acc_ofs),
        .fault(chk_fault), .addr(chk_addr)
    );

    // Response register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_addr  <= '0;
            rsp_fault <= FLT_NONE;
        end else begin
            rsp_valid <= acc_valid;
            rsp_addr  <= acc_valid ? chk_addr : '0;
            rsp_fault <= acc_valid ? chk_fault : FLT_NONE;
        end
    end

    p_resp_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> rsp_valid);
    p_no_spurious_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !rsp_valid);
    p_fault_addr_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault != FLT_NONE) |-> rsp_addr == '0);
    p_no_rsvd_fault_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault != FLT_RSVD);
    p_cpl_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!desc_we && !seg_we) |=> $stable(cur_pl));
endmodule

// File: tb/test_seg_xlate_unit.sv
module test_seg_xlate_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        desc_we = 1'b0;
    logic [2:0]  desc_idx = '0;
    logic [63:0] desc_wdata = '0;
    logic        seg_we = 1'b0;
    logic [1:0]  seg_wid = '0;
    logic [15:0] seg_wdata = '0;
    logic        acc_valid = 1'b0;
    logic [1:0]  acc_kind = '0;
    logic        ovr_en = 1'b0;
    logic [1:0]  ovr_seg = '0;
    logic [15:0] acc_ofs = '0;
    logic        rsp_valid;
    logic [23:0] rsp_addr;
    logic [1:0]  rsp_fault;
    logic [1:0]  cur_pl;

    int n_chk = 0;
    int n_err = 0;
    logic [63:0] m_desc [8];
    logic [15:0] m_seg [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    seg_xlate_unit i_seg_xlate_unit (
        .clk(clk), .rst_n(rst_n), .desc_we(desc_we), .desc_idx(desc_idx),
        .desc_wdata(desc_wdata), .seg_we(seg_we), .seg_wid(seg_wid),
        .seg_wdata(seg_wdata), .acc_valid(acc_valid), .acc_kind(acc_kind),
        .ovr_en(ovr_en), .ovr_seg(ovr_seg), .acc_ofs(acc_ofs),
        .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_fault(rsp_fault),
        .cur_pl(cur_pl)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] mk(logic [23:0] b, logic [15:0] l,
                                       logic [1:0] p, logic [21:0] junk);
        return {junk, p, b, l};
    endfunction

    function automatic logic [1:0] m_cpl();
        return m_desc[m_seg[1][2:0]][41:40];
    endfunction

    // Expected {fault, addr} per R2..R9
    function automatic logic [25:0] expect_rsp(logic [1:0] k, logic oe,
                                               logic [1:0] os, logic [15:0] o);
        logic [1:0]  s;
        logic [63:0] d;
        s = (k == 2'd0) ? 2'd1 : (oe ? os : ((k == 2'd3) ? 2'd2 : 2'd3));
        d = m_desc[m_seg[s][2:0]];
        if (o > d[15:0])            return {2'd1, 24'h0};
        else if (m_cpl() > d[41:40]) return {2'd2, 24'h0};
        else                         return {2'd0, d[39:16] + {8'h0, o}};
    endfunction

    task automatic wr_desc(logic [2:0] i, logic [63:0] w);
        desc_we = 1'b1; desc_idx = i; desc_wdata = w;
        @(negedge clk);
        m_desc[i] = w;
        desc_we = 1'b0;
    endtask

    task automatic wr_seg(logic [1:0] i, logic [15:0] w);
        seg_we = 1'b1; seg_wid = i; seg_wdata = w;
        @(negedge clk);
        m_seg[i] = w;
        seg_we = 1'b0;
    endtask

    task automatic access(string req, logic [1:0] k, logic oe,
                          logic [1:0] os, logic [15:0] o);
        logic [25:0] e;
        e = expect_rsp(k, oe, os, o);
        acc_valid = 1'b1; acc_kind = k; ovr_en = oe; ovr_seg = os; acc_ofs = o;
        @(negedge clk);
        acc_valid = 1'b0;
        chk({req, " valid"}, {31'h0, rsp_valid}, 32'd1);
        chk({req, " resp"}, {6'h0, rsp_fault, rsp_addr}, {6'h0, e});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [25:0] e;
        void'($urandom(32'd4242));
        for (int i = 0; i < 8; i++) m_desc[i] = '0;
        for (int i = 0; i < 4; i++) m_seg[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11 valid", {31'h0, rsp_valid}, 32'd0);
        chk("R11 addr", {8'h0, rsp_addr}, 32'd0);
        chk("R11 fault", {30'h0, rsp_fault}, 32'd0);
        chk("R11 cur_pl", {30'h0, cur_pl}, 32'd0);
        // R1 no response while idle
        @(negedge clk);
        chk("R1 idle", {31'h0, rsp_valid}, 32'd0);

        wr_desc(3'd1, mk(24'h000100, 16'hFFFF, 2'd0, 22'h0));
        wr_desc(3'd2, mk(24'h123400, 16'h0FFF, 2'd3, 22'h3ABCD)); // R5 junk
        wr_seg(2'd1, 16'h0001);
        wr_seg(2'd3, 16'hA502);                                     // R4 junk
        access("R4 R5 R6 at limit", 2'd1, 1'b0, 2'd0, 16'h0FFF);
        chk("R6 addr value", {8'h0, rsp_addr}, 32'h001243FF);
        access("R7 limit+1", 2'd2, 1'b0, 2'd0, 16'h1000);
        chk("R7 code", {30'h0, rsp_fault}, 32'd1);
        chk("R9 zero addr", {8'h0, rsp_addr}, 32'd0);
        @(negedge clk);
        chk("R1 single pulse", {31'h0, rsp_valid}, 32'd0);

        wr_desc(3'd1, mk(24'h000100, 16'hFFFF, 2'd2, 22'h0));
        chk("R8 cur_pl", {30'h0, cur_pl}, 32'd2);
        wr_desc(3'd3, mk(24'h050000, 16'h0010, 2'd1, 22'h0));
        wr_desc(3'd5, mk(24'h060000, 16'h0010, 2'd2, 22'h0));
        wr_seg(2'd2, 16'h0003);
        access("R8 priv fault", 2'd3, 1'b0, 2'd0, 16'h0005);
        chk("R8 code", {30'h0, rsp_fault}, 32'd2);
        access("R8 limit over priv", 2'd3, 1'b0, 2'd0, 16'h0020);
        chk("R8 priority", {30'h0, rsp_fault}, 32'd1);
        wr_seg(2'd2, 16'h0005);
        access("R8 equal level ok", 2'd3, 1'b0, 2'd0, 16'h0010);
        access("R2 fetch", 2'd0, 1'b0, 2'd0, 16'h0042);
        access("R3 fetch ignores override", 2'd0, 1'b1, 2'd2, 16'h0042);
        chk("R3 fetch addr", {8'h0, rsp_addr}, 32'h00000142);
        wr_desc(3'd4, mk(24'hFFFFF0, 16'hFFFF, 2'd3, 22'h0));
        wr_seg(2'd0, 16'h0004);
        access("R3 override extra wrap R6", 2'd1, 1'b1, 2'd0, 16'h0020);
        chk("R6 wrap", {8'h0, rsp_addr}, 32'h00000010);

        // R10 same-cycle write sees old contents
        e = expect_rsp(2'd1, 1'b1, 2'd0, 16'h0020);
        desc_we = 1'b1; desc_idx = 3'd4;
        desc_wdata = mk(24'h000000, 16'h0001, 2'd3, 22'h0);
        acc_valid = 1'b1; acc_kind = 2'd1; ovr_en = 1'b1; ovr_seg = 2'd0;
        acc_ofs = 16'h0020;
        @(negedge clk);
        m_desc[4] = desc_wdata;
        desc_we = 1'b0; acc_valid = 1'b0;
        chk("R10 old contents", {6'h0, rsp_fault, rsp_addr}, {6'h0, e});
        access("R10 new contents", 2'd1, 1'b1, 2'd0, 16'h0020);

        // Seeded random mix
        for (int n = 0; n < 600; n++) begin
            int r;
            r = $urandom % 8;
            if (r == 0) begin
                logic [15:0] l;
                l = ($urandom % 2) ? 16'($urandom) : 16'($urandom % 64);
                wr_desc(3'($urandom), mk(24'($urandom), l, 2'($urandom),
                                         22'($urandom)));
            end else if (r == 1) begin
                wr_seg(2'($urandom), 16'($urandom));
                chk("R8 cur_pl random", {30'h0, cur_pl}, {30'h0, m_cpl()});
            end else begin
                logic [15:0] o;
                o = ($urandom % 2) ? 16'($urandom) : 16'($urandom % 80);
                access("R2 R3 R6 R7 R8 random", 2'($urandom), 1'($urandom),
                       2'($urandom), o);
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule